// File: doc/BRIEF.md
# Flash Device Power-Mode Controller

This block holds the control and power-state logic of a parallel NOR flash device. It watches the device's chip-enable, output-enable, write-enable and combined reset/power-down pins, the address bus, and a busy flag from the program/erase engine. From these it keeps one of four power modes: deep power-down, standby, active, and automatic power savings. The array, the supplies and the program/erase algorithms sit outside the block.

Pulling the reset/power-down pin low does several things at once. It puts the device in its deepest state and floats the data bus. It aborts any program or erase in flight and marks the touched contents as invalid. It also clears the status register and resets the command interface.

Releasing the pin starts a recovery count. No data is driven and no command is accepted until that count has run out. Standby is held off while the engine is busy. After a read has settled on a stable address, the device drops into automatic power savings with its outputs still driven, and it leaves that state when the address moves.

Top module: `fpm_ctrl`

## Requirements
- R1: While `rp_n` is low, `dq_oe` and `cmd_wr_en` are low in the same cycle, whatever the other inputs are. `pmode` is 2'b00 from the next rising edge.
- R2: `eng_abort` is high while `rp_n` is low and `eng_busy` is high. A clock edge that samples this condition sets `data_invalid`. `data_invalid` then stays high until `por_n` goes low.
- R3: `stat_clr` is high whenever `rp_n` is low or `por_n` is low.
- R4: `cui_reset` is high while `rp_n` is low and for as long as `pmode` is 2'b00, so the command interface comes back in read-array mode.
- R5: Recovery starts when `rp_n` is sampled high after being low, or when `por_n` is released. `pmode` stays 2'b00 and `not_ready` stays high for REC_CYC+1 rising edges, counted from that first high sample. During this time `dq_oe` and `cmd_wr_en` stay low.
- R6: With `ce_n` high and `eng_busy` low, the next edge gives `pmode` = 2'b01 (standby). `dq_oe` is low whenever `ce_n` is high, whatever `oe_n` is.
- R7: With `ce_n` high and `eng_busy` high, outside power-down, `pmode` is 2'b10 (active) at each edge until `eng_busy` falls.
- R8: `cmd_wr_en` is high only when `ce_n` and `we_n` are both low, `rp_n` is high and `not_ready` is low.
- R9: Take a cycle in which `pmode` = 2'b10, `ce_n` and `oe_n` are low, `we_n` is high, `eng_busy` is low, and the address equals the previous cycle's address. The next edge gives `pmode` = 2'b11, provided the parameter APS_EN is 1 (the default). While `ce_n` is low, `pmode` = 2'b11 holds as long as the address stays unchanged and the engine is idle. `dq_oe` stays high in this mode while `ce_n` and `oe_n` are low.
- R10: From `pmode` = 2'b11 with `ce_n` low, an address that differs from the previous cycle's gives `pmode` = 2'b10 at the next edge.
- R11: `pmode` encodes deep power-down 2'b00, standby 2'b01, active 2'b10 and power savings 2'b11. While `por_n` is low, `pmode` = 2'b00, `not_ready` = 1 and `data_invalid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| rp_n | input | 1 | Reset/deep power-down pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| eng_busy | input | 1 | Program/erase engine running |
| dq_oe | output | 1 | Drive enable for the data bus |
| eng_abort | output | 1 | Abort request to the engine |
| stat_clr | output | 1 | Status register clear |
| cui_reset | output | 1 | Command interface reset to read-array mode |
| cmd_wr_en | output | 1 | Command write accepted this cycle |
| data_invalid | output | 1 | An operation was aborted, so array contents are suspect |
| not_ready | output | 1 | Power-down or recovery still in progress |
| pmode | output | 2 | Current power mode |

## Verification
The bench tests the exact length of the recovery window. A counter that is off by one would let `dq_oe` or `cmd_wr_en` come up one cycle early, or hold `pmode` at 2'b00 one cycle too long. It raises chip-enable while the engine is busy: a design that ignored the busy flag would fall into standby in the middle of an erase. It pulls the power-down pin low during a busy read. A design that waited for an edge to float the bus, or failed to latch `data_invalid`, would show up at once. It also moves the address while in power savings and checks that the mode returns to active exactly one edge later.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      PM_DPD  = 2'b00,
      PM_STBY = 2'b01,
      PM_ACT  = 2'b10,
      PM_APS  = 2'b11
   } pmode_e;
endpackage

// File: rtl/fpm_recovery.sv
// Wake-up counter: reloads while the power-down pin is low and counts
// down once it is released; rec_done marks the end of the window.
module fpm_recovery #(
   parameter int REC_CYC = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic rp_n,
   output logic rec_done
);
   localparam int CW = $clog2(REC_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(REC_CYC);

   generate
      if (REC_CYC < 1) begin : g_bad_rec
         $error("fpm_recovery: REC_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= LOAD;
      end else if (!rp_n) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rec_done = (cnt_q == '0);

   // R5: a power-down cycle always reopens the recovery window
   a_r5_reload: assert property (@(posedge clk) disable iff (!por_n)
      !rp_n |=> !rec_done);
endmodule

// File: rtl/fpm_addr_watch.sv
// Registers the bus address every cycle and flags a new value.
module fpm_addr_watch #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic [AW-1:0] addr,
   output logic          addr_chg
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("fpm_addr_watch: AW must be at least 1");
      end
   endgenerate

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   assign addr_chg = (addr != addr_q);
endmodule

// File: rtl/fpm_mode_fsm.sv
// Power-mode state register and next-mode selection.
module fpm_mode_fsm
   import fpm_pkg::*;
#(
   parameter bit APS_EN = 1'b1
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   rp_n,
   input  logic   rec_done,
   input  logic   ce_n,
   input  logic   oe_n,
   input  logic   we_n,
   input  logic   eng_busy,
   input  logic   addr_chg,
   output pmode_e mode
);
   pmode_e mode_q, mode_d;
   logic   settle_go;   // a read has sat on one address for a full cycle
   logic   aps_keep;    // power savings may be held this cycle

   generate
      if (APS_EN) begin : g_aps
         assign settle_go = (mode_q == PM_ACT) && !oe_n && we_n && !addr_chg;
         assign aps_keep  = (mode_q == PM_APS) && !addr_chg;
      end else begin : g_no_aps
         assign settle_go = 1'b0;
         assign aps_keep  = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_d = mode_q;
      if (!rp_n || !rec_done) begin
         mode_d = PM_DPD;
      end else if (ce_n) begin
         mode_d = eng_busy ? PM_ACT : PM_STBY;
      end else if (eng_busy) begin
         mode_d = PM_ACT;
      end else if (aps_keep || settle_go) begin
         mode_d = PM_APS;
      end else begin
         mode_d = PM_ACT;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) mode_q <= PM_DPD;
      else        mode_q <= mode_d;
   end

   assign mode = mode_q;

   // R7: a running operation keeps the device active when deselected
   a_r7_busy_active: assert property (@(posedge clk) disable iff (!por_n)
      (rp_n && eng_busy && mode_q != PM_DPD) |=> (mode_q == PM_ACT));
   // R9: power savings persists on a still address and an idle engine
   a_r9_aps_hold: assert property (@(posedge clk) disable iff (!por_n)
      (rp_n && !ce_n && !eng_busy && mode_q == PM_APS && !addr_chg)
      |=> (mode_q == PM_APS));
   // R10: a new address wakes the device back to active
   a_r10_aps_exit: assert property (@(posedge clk) disable iff (!por_n)
      (rp_n && !ce_n && mode_q == PM_APS && addr_chg) |=> (mode_q == PM_ACT));
   // R6: idle and deselected means standby
   a_r6_standby: assert property (@(posedge clk) disable iff (!por_n)
      (rp_n && rec_done && ce_n && !eng_busy) |=> (mode_q == PM_STBY));
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
   import fpm_pkg::*;
#(
   parameter int AW      = 16,
   parameter int REC_CYC = 8,
   parameter bit APS_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rp_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic          eng_busy,
   output logic          dq_oe,
   output logic          eng_abort,
   output logic          stat_clr,
   output logic          cui_reset,
   output logic          cmd_wr_en,
   output logic          data_invalid,
   output logic          not_ready,
   output logic [1:0]    pmode
);
   logic   rec_done;
   logic   addr_chg;
   pmode_e mode;
   logic   awake;
   logic   inval_q;

   fpm_recovery #(.REC_CYC(REC_CYC)) u_rec (
      .clk      (clk),
      .por_n    (por_n),
      .rp_n     (rp_n),
      .rec_done (rec_done)
   );

   fpm_addr_watch #(.AW(AW)) u_addr (
      .clk      (clk),
      .por_n    (por_n),
      .addr     (addr),
      .addr_chg (addr_chg)
   );

   fpm_mode_fsm #(.APS_EN(APS_EN)) u_fsm (
      .clk      (clk),
      .por_n    (por_n),
      .rp_n     (rp_n),
      .rec_done (rec_done),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .eng_busy (eng_busy),
      .addr_chg (addr_chg),
      .mode     (mode)
   );

   // sticky marker for contents hit by an aborted program/erase
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  inval_q <= 1'b0;
      else if (!rp_n && eng_busy)  inval_q <= 1'b1;
   end

   assign awake        = rp_n && (mode != PM_DPD);
   assign not_ready    = (mode == PM_DPD);
   assign dq_oe        = awake && !ce_n && !oe_n &&
                         (mode == PM_ACT || mode == PM_APS);
   assign cmd_wr_en    = awake && !ce_n && !we_n;
   assign eng_abort    = !rp_n && eng_busy;
   assign stat_clr     = !rp_n || !por_n;
   assign cui_reset    = !rp_n || (mode == PM_DPD);
   assign data_invalid = inval_q;
   assign pmode        = mode;

   // R1: power-down floats the bus and blocks writes at once
   a_r1_dpd_quiet: assert property (@(posedge clk) disable iff (!por_n)
      !rp_n |-> (!dq_oe && !cmd_wr_en));
   // R1: power-down mode follows on the next edge
   a_r1_dpd_mode: assert property (@(posedge clk) disable iff (!por_n)
      !rp_n |=> (pmode == 2'b00));
   // R2: abort during an operation leaves the contents marked invalid
   a_r2_mark: assert property (@(posedge clk) disable iff (!por_n)
      (!rp_n && eng_busy) |=> data_invalid);
   a_r2_sticky: assert property (@(posedge clk) disable iff (!por_n)
      data_invalid |=> data_invalid);
   // R5: nothing is driven or accepted before recovery completes
   a_r5_blocked: assert property (@(posedge clk) disable iff (!por_n)
      not_ready |-> (!dq_oe && !cmd_wr_en && cui_reset));
endmodule

// File: tb/fpm_ctrl_test.sv
`timescale 1ns/1ps
module fpm_ctrl_test;
   localparam int AW  = 16;
   localparam int REC = 8;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic          eng_busy = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          dq_oe, eng_abort, stat_clr, cui_reset, cmd_wr_en;
   logic          data_invalid, not_ready;
   logic [1:0]    pmode;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   // reference model state
   int            m_mode = 0;
   int            m_rec  = REC;
   logic [AW-1:0] m_addr_q = '0;
   bit            m_inv  = 0;

   fpm_ctrl #(.AW(AW), .REC_CYC(REC)) uut (
      .clk(clk), .por_n(por_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .addr(addr), .eng_busy(eng_busy), .dq_oe(dq_oe),
      .eng_abort(eng_abort), .stat_clr(stat_clr), .cui_reset(cui_reset),
      .cmd_wr_en(cmd_wr_en), .data_invalid(data_invalid),
      .not_ready(not_ready), .pmode(pmode)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string nm,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                  req, nm, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // model update at each edge, full comparison shortly after
   always @(posedge clk) begin
      cyc++;
      if (!por_n) begin
         m_mode = 0; m_rec = REC; m_addr_q = '0; m_inv = 0;
      end else begin
         if (!rp_n) begin
            if (eng_busy) m_inv = 1;
            m_mode = 0; m_rec = REC;
         end else if (m_rec > 0) begin
            m_rec--; m_mode = 0;
         end else if (ce_n) begin
            m_mode = eng_busy ? 2 : 1;
         end else if (eng_busy) begin
            m_mode = 2;
         end else if (m_mode == 3) begin
            m_mode = (addr == m_addr_q) ? 3 : 2;
         end else if (m_mode == 2 && !oe_n && we_n && addr == m_addr_q) begin
            m_mode = 3;
         end else begin
            m_mode = 2;
         end
         m_addr_q = addr;
      end
      #5;
      chk("R11", "pmode", 32'(pmode), 32'(m_mode));
      chk("R1", "dq_oe", 32'(dq_oe),
          32'(rp_n && !ce_n && !oe_n && (m_mode == 2 || m_mode == 3)));
      chk("R8", "cmd_wr_en", 32'(cmd_wr_en),
          32'(rp_n && !ce_n && !we_n && m_mode != 0));
      chk("R2", "eng_abort", 32'(eng_abort), 32'(!rp_n && eng_busy));
      chk("R2", "data_invalid", 32'(data_invalid), 32'(m_inv));
      chk("R3", "stat_clr", 32'(stat_clr), 32'(!rp_n || !por_n));
      chk("R4", "cui_reset", 32'(cui_reset), 32'(!rp_n || m_mode == 0));
      chk("R5", "not_ready", 32'(not_ready), 32'(m_mode == 0));
      if (cyc > 5000) begin
         total++; bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   task automatic drive(input logic rp, input logic ce, input logic oe,
                        input logic we, input logic busy,
                        input logic [AW-1:0] a, input int n);
      rp_n = rp; ce_n = ce; oe_n = oe; we_n = we; eng_busy = busy; addr = a;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      repeat (3) @(negedge clk);
      // R11: power-up reset state
      chk("R11", "reset pmode", 32'(pmode), 32'd0);
      chk("R11", "reset not_ready", 32'(not_ready), 32'd1);
      chk("R11", "reset data_invalid", 32'(data_invalid), 32'd0);
      chk("R3", "stat_clr in por", 32'(stat_clr), 32'd1);
      por_n = 1'b1;
      // R5: recovery window after power-up
      drive(1, 1, 1, 1, 0, 16'h0000, REC);
      chk("R5", "still recovering", 32'(not_ready), 32'd1);
      drive(1, 1, 1, 1, 0, 16'h0000, 1);
      chk("R6", "standby after recovery", 32'(pmode), 32'd1);
      // R9: read, then power savings on a still address
      drive(1, 0, 0, 1, 0, 16'h1234, 1);
      chk("R9", "active on read", 32'(pmode), 32'd2);
      chk("R9", "dq_oe on read", 32'(dq_oe), 32'd1);
      drive(1, 0, 0, 1, 0, 16'h1234, 1);
      chk("R9", "enter savings", 32'(pmode), 32'd3);
      drive(1, 0, 0, 1, 0, 16'h1234, 3);
      chk("R9", "hold savings", 32'(pmode), 32'd3);
      chk("R9", "outputs valid in savings", 32'(dq_oe), 32'd1);
      // R10: a new address wakes it
      drive(1, 0, 0, 1, 0, 16'hBEEF, 1);
      chk("R10", "exit on new address", 32'(pmode), 32'd2);
      drive(1, 0, 0, 1, 0, 16'hBEEF, 1);
      chk("R9", "re-enter savings", 32'(pmode), 32'd3);
      // R8: command write gating
      drive(1, 0, 1, 0, 0, 16'hBEEF, 1);
      chk("R8", "write accepted", 32'(cmd_wr_en), 32'd1);
      drive(1, 1, 0, 0, 0, 16'hBEEF, 1);
      chk("R8", "write blocked by ce_n", 32'(cmd_wr_en), 32'd0);
      chk("R6", "hi-z with oe_n low", 32'(dq_oe), 32'd0);
      chk("R6", "standby", 32'(pmode), 32'd1);
      // R7: operation running while deselected
      drive(1, 1, 1, 1, 1, 16'h0001, 1);
      chk("R7", "active while busy", 32'(pmode), 32'd2);
      drive(1, 1, 1, 1, 1, 16'h0002, 3);
      chk("R7", "still active", 32'(pmode), 32'd2);
      drive(1, 1, 1, 1, 0, 16'h0002, 1);
      chk("R6", "standby after completion", 32'(pmode), 32'd1);
      // R1/R2: power-down during a busy read
      drive(1, 0, 0, 1, 1, 16'h0003, 2);
      drive(0, 0, 0, 1, 1, 16'h0003, 0);
      #1;
      chk("R2", "abort strobe", 32'(eng_abort), 32'd1);
      chk("R1", "bus floated at once", 32'(dq_oe), 32'd0);
      chk("R3", "status clear", 32'(stat_clr), 32'd1);
      @(negedge clk);
      chk("R1", "deep power-down", 32'(pmode), 32'd0);
      chk("R2", "contents invalid", 32'(data_invalid), 32'd1);
      drive(0, 0, 0, 0, 0, 16'h0003, 2);
      chk("R1", "no write in power-down", 32'(cmd_wr_en), 32'd0);
      // R5/R4: release with the device selected and reading
      drive(1, 0, 0, 1, 0, 16'h0004, REC);
      chk("R5", "outputs held off", 32'(dq_oe), 32'd0);
      chk("R4", "command interface held", 32'(cui_reset), 32'd1);
      drive(1, 0, 0, 1, 0, 16'h0004, 1);
      chk("R5", "ready after window", 32'(not_ready), 32'd0);
      chk("R4", "command interface released", 32'(cui_reset), 32'd0);
      chk("R2", "invalid is sticky", 32'(data_invalid), 32'd1);
      // R11: power-up reset clears the marker
      por_n = 1'b0;
      @(negedge clk);
      chk("R11", "por clears invalid", 32'(data_invalid), 32'd0);
      @(negedge clk);
      finish_run();
   end
endmodule